// File: doc/BRIEF.md
# Flash Line Read Accelerator

This block sits between a bus read port and a slow flash array. Its job is to hide the array's access time. Four 128-bit line buffers serve reads to the first bank. A single 128-bit holding register serves the second bank. A read that finds its line is answered in the next cycle. A read that misses drives the line address to the array and holds it for a programmable number of array cycles. It then captures the whole line and returns the requested 32-bit word.

After a demand miss in the first bank, the block reads the next sequential line ahead of time, provided no buffer already holds it. Buffer replacement follows a strict recency order. A line loaded on demand becomes most recent immediately. A line loaded ahead of time is placed in the least recent slot and stays there until a read actually uses it. Writes are not carried out here. A write only discards any buffered copy of the addressed line.

Top module: `flash_line_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `arr_req` is 0, and every buffer and the holding register are empty.
- R2: A read that misses keeps `arr_req` high with `arr_line` = address bits [15:4] for `wait_cfg`+1 cycles. The word selected by address bits [3:2] (word k at line bits 32k+31..32k) then appears with `rsp_valid` in the cycle after the last array cycle. Counted from the request being driven in an idle cycle, that is `wait_cfg`+2 cycles.
- R3: A read that hits is accepted at once and answered in the next cycle, with no array access.
- R4: A demand miss in the first bank replaces the least recent buffer and makes that buffer the most recent. A read hit also makes its buffer the most recent.
- R5: When a first-bank demand fill completes and no buffer holds the next line, the next-line fetch starts in the cycle after the fill. It loads into the buffer that is then least recent and leaves the recency order unchanged. A later demand miss therefore replaces that buffer if no read has touched it.
- R6: A read that hits a line loaded ahead of time makes that line the most recent. The line then survives the next demand miss.
- R7: While a next-line fetch is running, reads that hit are served. Reads that miss, and all writes, are held off with `req_ready` low until the fetch completes.
- R8: Address bit 15 set selects the second bank. A miss there loads the holding register and starts no next-line fetch. A read to the held line hits with zero wait states.
- R9: A write (`req_write`=1) is accepted only when no array access is running. It is answered in the next cycle with `rsp_data` = 0. It discards the buffer or holding register that holds its line, and it leaves every other entry unchanged.
- R10: The next line is the line index (address bits [14:4]) plus one, wrapping from 0x7FF to 0 within the first bank.
- R11: A `wait_cfg` value of 0 means one array cycle, so an idle miss is answered 2 cycles after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_cfg | input | 4 | Array read cycles minus one |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address; bit 15 selects the bank |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Response word |
| arr_req | output | 1 | Array access in progress |
| arr_line | output | 12 | Line address to the array (bank bit and line index) |
| arr_rdata | input | 128 | Line data from the array |

## Verification
The assertions check the following on every cycle: the recency order stays a permutation, the line address holds steady through a miss, an accepted hit or write is answered in the next cycle, and a buffer being loaded ahead of time can never hit. Other properties only show up in the bench's directed scenarios and random traffic, because they depend on a sequence of earlier reads. These include which buffer a miss evicts, the fact that an unused next-line load is the first one lost, promotion on a hit, address wrap, and discarding on write. A behavioural model compares all outputs against these scenarios on every clock.

// File: rtl/flash_line_cache.sv
module flash_line_cache #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4,
  parameter int NBUF   = 4
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WAIT_W-1:0]   wait_cfg,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [31:0]         rsp_data,
  output logic                arr_req,
  output logic [ADDR_W-5:0]   arr_line,
  input  logic [127:0]        arr_rdata
);
  localparam int TAG_W  = ADDR_W - 4;
  localparam int IDX_W  = TAG_W - 1;
  localparam int RANK_W = $clog2(NBUF);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_FETCH = 2'd1, S_PREF = 2'd2} st_t;

  logic [TAG_W-1:0]  tag_q  [NBUF];
  logic [127:0]      line_q [NBUF];
  logic [RANK_W-1:0] rank_q [NBUF];
  logic [NBUF-1:0]   vld_q;
  logic [TAG_W-1:0]  hold_tag_q;
  logic [127:0]      hold_line_q;
  logic              hold_vld_q;
  st_t               st_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [TAG_W-1:0]  ftag_q;
  logic [1:0]        fword_q;
  logic [RANK_W-1:0] fslot_q;

  logic [TAG_W-1:0]  rtag, pf_tag;
  logic [NBUF-1:0]   hitv;
  logic [RANK_W-1:0] hit_idx, lru_idx, r2_idx, touch_idx;
  logic              pf_present, hold_hit, hit, done, acc, fill, fb1, touch_en, start_pf;
  logic              unused_lo;

  function automatic logic [31:0] wsel(input logic [127:0] l, input logic [1:0] w);
    return l[{w, 5'b0} +: 32];
  endfunction

  assign rtag      = req_addr[ADDR_W-1:4];
  assign unused_lo = ^req_addr[1:0];
  assign fb1       = ftag_q[TAG_W-1];
  assign pf_tag    = {1'b0, ftag_q[IDX_W-1:0] + IDX_W'(1)};

  always_comb begin
    hitv = '0; hit_idx = '0; lru_idx = '0; r2_idx = '0; pf_present = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      hitv[i] = vld_q[i] && tag_q[i] == rtag && !req_addr[ADDR_W-1];
      if (hitv[i]) hit_idx = RANK_W'(i);
      if (rank_q[i] == RANK_W'(NBUF-1)) lru_idx = RANK_W'(i);
      if (rank_q[i] == RANK_W'(NBUF-2)) r2_idx = RANK_W'(i);
      if (vld_q[i] && tag_q[i] == pf_tag && RANK_W'(i) != fslot_q) pf_present = 1'b1;
    end
  end

  assign hold_hit  = hold_vld_q && hold_tag_q == rtag && req_addr[ADDR_W-1];
  assign hit       = (|hitv) || hold_hit;
  assign done      = cnt_q == wait_cfg;
  assign req_ready = st_q == S_IDLE || (st_q == S_PREF && !req_write && hit);
  assign acc       = req_valid && req_ready;
  assign fill      = st_q == S_FETCH && done;
  assign touch_en  = (acc && !req_write && |hitv) || (fill && !fb1);
  assign touch_idx = fill ? fslot_q : hit_idx;
  assign start_pf  = fill && !fb1 && !pf_present;
  assign arr_req   = st_q != S_IDLE;
  assign arr_line  = ftag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; ftag_q <= '0; fword_q <= '0; fslot_q <= '0;
      vld_q <= '0; hold_vld_q <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0;
      for (int i = 0; i < NBUF; i++) rank_q[i] <= RANK_W'(i);
    end else begin
      rsp_valid <= 1'b0;
      if (touch_en)
        for (int i = 0; i < NBUF; i++)
          if (RANK_W'(i) == touch_idx) rank_q[i] <= '0;
          else if (rank_q[i] < rank_q[touch_idx]) rank_q[i] <= rank_q[i] + RANK_W'(1);
      if (acc) begin
        rsp_valid <= 1'b1;
        if (req_write) begin
          rsp_data   <= '0;
          vld_q      <= vld_q & ~hitv;
          if (hold_hit) hold_vld_q <= 1'b0;
        end else if (hit) begin
          rsp_data <= hold_hit ? wsel(hold_line_q, req_addr[3:2]) : wsel(line_q[hit_idx], req_addr[3:2]);
        end else begin
          rsp_valid <= 1'b0;
          st_q <= S_FETCH; cnt_q <= '0; ftag_q <= rtag; fword_q <= req_addr[3:2]; fslot_q <= lru_idx;
          if (!req_addr[ADDR_W-1]) vld_q[lru_idx] <= 1'b0;
        end
      end
      if (st_q != S_IDLE) begin
        if (!done) cnt_q <= cnt_q + WAIT_W'(1);
        else if (st_q == S_PREF) begin
          vld_q[fslot_q] <= 1'b1; st_q <= S_IDLE;
        end else begin
          rsp_valid <= 1'b1;
          rsp_data  <= wsel(arr_rdata, fword_q);
          st_q      <= S_IDLE;
          if (fb1) hold_vld_q <= 1'b1;
          else begin
            vld_q[fslot_q] <= 1'b1;
            if (start_pf) begin
              st_q <= S_PREF; cnt_q <= '0; ftag_q <= pf_tag; fslot_q <= r2_idx;
              vld_q[r2_idx] <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_q != S_IDLE && done) begin
      if (st_q == S_FETCH && fb1) begin
        hold_line_q <= arr_rdata; hold_tag_q <= ftag_q;
      end else begin
        line_q[fslot_q] <= arr_rdata; tag_q[fslot_q] <= ftag_q;
      end
      if (start_pf) tag_q[r2_idx] <= pf_tag;
    end
  end
endmodule

// File: rtl/flash_line_cache_chk.sv
module flash_line_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int NBUF   = 4
)(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic                      req_ready,
  input logic                      hit,
  input logic                      rsp_valid,
  input logic [31:0]               rsp_data,
  input logic                      arr_req,
  input logic [ADDR_W-5:0]         arr_line,
  input logic [1:0]                st,
  input logic [NBUF-1:0]           vld,
  input logic [$clog2(NBUF)-1:0]   fslot,
  input logic [$clog2(NBUF)-1:0]   rank [NBUF]
);
  logic [NBUF-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NBUF; i++) seen[rank[i]] = 1'b1;
  end

  AST_RANK_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);                                                                   // R4
  AST_LINE_HELD_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) == 2'd1) |-> $stable(arr_line));                 // R2
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && hit) |=> rsp_valid);             // R3
  AST_WRITE_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_valid && rsp_data == 32'd0 && !arr_req)); // R9
  AST_PREF_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd2 |-> !vld[fslot]);                                              // R5
  AST_FETCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd1 |-> !req_ready);                                               // R7
endmodule

bind flash_line_cache flash_line_cache_chk #(.ADDR_W(ADDR_W), .NBUF(NBUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .hit(hit), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .arr_req(arr_req), .arr_line(arr_line), .st(st_q), .vld(vld_q),
  .fslot(fslot_q), .rank(rank_q)
);

// File: tb/flash_line_cache_tb.sv
module flash_line_cache_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] wait_cfg = 4'd3;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic req_ready, rsp_valid, arr_req;
  logic [31:0] rsp_data;
  logic [11:0] arr_line;
  logic [127:0] arr_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] wf(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction
  function automatic logic [127:0] linef(input logic [11:0] t);
    return {wf({t, 4'hC}), wf({t, 4'h8}), wf({t, 4'h4}), wf({t, 4'h0})};
  endfunction
  assign arr_rdata = linef(arr_line);

  flash_line_cache u_dut (
    .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .arr_req(arr_req),
    .arr_line(arr_line), .arr_rdata(arr_rdata)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  // reference model: queue holds buffer ids, front = most recent
  int m_st, m_cnt, m_fslot;
  logic [11:0] m_ftag, m_htag;
  logic [1:0] m_fword;
  logic [11:0] m_tag [4];
  bit m_vld [4];
  bit m_hvld;
  int m_ord [$];
  bit e_rv;
  logic [31:0] e_rd;

  function automatic int m_find(input logic [15:0] a);
    if (a[15]) return (m_hvld && m_htag == a[15:4]) ? -2 : -1;
    for (int b = 0; b < 4; b++) if (m_vld[b] && m_tag[b] == a[15:4]) return b;
    return -1;
  endfunction
  function automatic bit m_ready();
    return m_st == 0 || (m_st == 2 && !req_write && m_find(req_addr) != -1);
  endfunction
  task automatic m_promote(input int b);
    for (int k = 0; k < m_ord.size(); k++)
      if (m_ord[k] == b) begin m_ord.delete(k); break; end
    m_ord.push_front(b);
  endtask

  always @(posedge clk) begin
    int s, f;
    bit acc, present;
    logic [11:0] pt;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ftag = '0; m_hvld = 0; e_rv = 0; e_rd = '0;
      m_ord = {0, 1, 2, 3};
      for (int b = 0; b < 4; b++) m_vld[b] = 0;
    end else begin
      s = m_st; f = m_find(req_addr); acc = req_valid && m_ready();
      e_rv = 0;
      if (acc && req_write) begin
        e_rv = 1; e_rd = '0;
        if (f == -2) m_hvld = 0; else if (f >= 0) m_vld[f] = 0;
      end else if (acc && f != -1) begin
        e_rv = 1; e_rd = wf({req_addr[15:2], 2'b00});
        if (f >= 0) m_promote(f);
      end else if (acc) begin
        m_st = 1; m_cnt = 0; m_ftag = req_addr[15:4]; m_fword = req_addr[3:2];
        if (!req_addr[15]) begin m_fslot = m_ord[3]; m_vld[m_fslot] = 0; end
      end
      if (s != 0) begin
        if (m_cnt != int'(wait_cfg)) m_cnt++;
        else if (s == 2) begin
          m_vld[m_fslot] = 1; m_st = 0;
        end else begin
          e_rv = 1; e_rd = wf({m_ftag, m_fword, 2'b00}); m_st = 0;
          if (m_ftag[11]) begin m_htag = m_ftag; m_hvld = 1; end
          else begin
            m_tag[m_fslot] = m_ftag; m_vld[m_fslot] = 1; m_promote(m_fslot);
            pt = {1'b0, m_ftag[10:0] + 11'd1};
            present = 0;
            for (int b = 0; b < 4; b++) if (m_vld[b] && m_tag[b] == pt) present = 1;
            if (!present) begin
              m_fslot = m_ord[3]; m_vld[m_fslot] = 0; m_tag[m_fslot] = pt;
              m_ftag = pt; m_st = 2; m_cnt = 0;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rsp_valid === e_rv, "R3/R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rv});
      if (e_rv) chk(rsp_data === e_rd, "R2/R8 rsp_data", rsp_data, e_rd);
      chk(arr_req === (m_st != 0), "R5 arr_req", {31'd0, arr_req}, {31'd0, m_st != 0});
      if (m_st != 0) chk(arr_line === m_ftag, "R5/R10 arr_line", {20'd0, arr_line}, {20'd0, m_ftag});
      #1;
      chk(req_ready === m_ready(), "R7 req_ready", {31'd0, req_ready}, {31'd0, m_ready()});
    end
  end

  task automatic rd(input logic wr, input logic [15:0] a, output int lat);
    lat = 0; req_valid = 1; req_write = wr; req_addr = a; #1;
    while (!req_ready) begin @(negedge clk); lat++; #1; end
    @(negedge clk); lat++; req_valid = 0; req_write = 0;
    while (!rsp_valid) begin @(negedge clk); lat++; end
  endtask
  task automatic wait_idle();
    while (arr_req) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    finish_run();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", {31'd0, req_ready}, 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid", {31'd0, rsp_valid}, 0);
    chk(arr_req === 1'b0, "R1 arr_req", {31'd0, arr_req}, 0);
    rst_n = 1;
    @(negedge clk);
    rd(0, 16'h0004, lat); chk(lat == 5, "R1/R2 first miss latency", lat, 5);
    rd(0, 16'h0018, lat); chk(lat == 5, "R7 miss held behind next-line load", lat, 5);
    rd(0, 16'h001C, lat); chk(lat == 1, "R6 hit on loaded-ahead line", lat, 1);
    wait_idle();
    wait_cfg = 4'd0;
    rd(0, 16'h0200, lat); chk(lat == 2, "R11 zero wait setting", lat, 2);
    wait_idle();
    wait_cfg = 4'd2;
    rd(0, 16'h0300, lat); wait_idle();
    rd(0, 16'h0500, lat); wait_idle();
    rd(0, 16'h0310, lat); chk(lat == 4, "R5 unused next line evicted first", lat, 4);
    wait_idle();
    rd(0, 16'h0700, lat); wait_idle();
    rd(0, 16'h0714, lat); chk(lat == 1, "R6 promote", lat, 1);
    rd(0, 16'h0900, lat); wait_idle();
    rd(0, 16'h0718, lat); chk(lat == 1, "R6 promoted line kept", lat, 1);
    rd(0, 16'h0904, lat); chk(lat == 1, "R4 demand line most recent", lat, 1);
    wait_idle();
    rd(0, 16'h8020, lat); chk(lat == 4, "R8 second bank miss", lat, 4);
    chk(arr_req === 1'b0, "R8 no next-line load", {31'd0, arr_req}, 0);
    rd(0, 16'h8028, lat); chk(lat == 1, "R8 holding hit", lat, 1);
    rd(0, 16'h8040, lat); chk(lat == 4, "R8 holding replaced", lat, 4);
    rd(0, 16'h8020, lat); chk(lat == 4, "R8 old line gone", lat, 4);
    rd(0, 16'h0A00, lat); wait_idle();
    rd(1, 16'h0A04, lat); chk(lat == 1 && rsp_data == 0, "R9 write ack", rsp_data, 0);
    rd(0, 16'h0A08, lat); chk(lat == 4, "R9 written line discarded", lat, 4);
    wait_idle();
    rd(1, 16'h8024, lat);
    rd(0, 16'h8024, lat); chk(lat == 4, "R9 holding discarded", lat, 4);
    rd(1, 16'h0F00, lat);
    rd(0, 16'h0A0C, lat); chk(lat == 1, "R9 other lines kept", lat, 1);
    wait_idle();
    rd(0, 16'h7FF0, lat);
    chk(arr_req === 1'b1 && arr_line === 12'h000, "R10 wrap", {20'd0, arr_line}, 0);
    wait_idle();
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) begin wait_idle(); wait_cfg = 4'($urandom_range(0, 5)); end
      rd(($urandom % 8) == 0, {1'($urandom), 7'd0, 4'($urandom_range(0, 11)), 2'($urandom), 2'b00}, lat);
    end
    wait_idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule